// File: doc/BRIEF.md
# Host Parallel Bus Bridge for a Character Display Controller

This block sits between a host processor's strobed parallel bus and the core of a character display controller. The host presents a register select (RS), a read/write line (R/W) and an enable strobe (E), and moves bytes over an eight-line data path. The bridge samples those pins on its own system clock and treats E as a strobe whose rising and falling edges it detects. Writes go to the core as single-cycle requests. Reads return one of two things: a status byte made of the core's busy flag and its 7-bit address counter, or a data byte that the core fetched earlier.

The host bus can run eight lines wide, or four lines wide using only the upper four data lines. In the four-line mode each byte takes two E cycles, high nibble first. After reset the bridge runs eight lines wide. Instruction writes are watched for the width-select command, which switches the bridge between the two widths. The data output and its output enable model a tri-state bus: the enable is high only while a read cycle holds E high.

Data reads follow a prefetch scheme. Once a data-read byte is complete, the bridge asks the core for the next byte and keeps the acknowledged value in a buffer. The following data read returns that buffer.

Top module: `mpu_bus_bridge`

## Requirements
- R1: After reset the bridge is in 8-bit mode, `bus_oe` is 0, `core_req` is 0 and the read buffer holds 0x00.
- R2: In 8-bit mode, an E cycle with RS=0 and R/W=0 issues exactly one `core_req` after E falls, with `core_sel`=0, `core_wr`=1 and `core_wdata` equal to the eight data lines.
- R3: In 8-bit mode, an E cycle with RS=1 and R/W=0 issues exactly one `core_req` with `core_sel`=1, `core_wr`=1 and the written byte.
- R4: A cycle with RS=0 and R/W=1 drives the status byte {`core_busy`, `core_ac[6:0]`}, with the busy flag in bit 7, and issues no core request.
- R5: `bus_oe` is 1 only while a read cycle (R/W=1) holds E high. It is 0 during write cycles and whenever E is low.
- R6: An instruction byte whose bits 7..5 are 001 selects the bus width from bit 4: 0 selects 4-bit mode and 1 selects 8-bit mode. The switch clears the nibble phase.
- R7: In 4-bit mode a write takes two E cycles. The high nibble comes first on data lines 7..4, then the low nibble. Data lines 3..0 are ignored. One request carrying the assembled byte follows the second cycle only.
- R8: In 4-bit mode a read returns the high nibble on the first E cycle and the low nibble on the second, both on `bus_dout[7:4]`, with `bus_dout[3:0]`=0. For a status read the second nibble is AC3..AC0.
- R9: A completed data read (RS=1, R/W=1) issues one request with `core_sel`=1 and `core_wr`=0. The `core_rdata` value accepted with `core_ack` is the byte the next data read returns.
- R10: The nibble phase returns to the high nibble whenever RS or R/W differs from the previous transfer's values. A half-finished pair then issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_e | input | 1 | Host enable strobe |
| bus_rs | input | 1 | Host register select (0 instruction/status, 1 data) |
| bus_rw | input | 1 | Host direction (0 write, 1 read) |
| bus_din | input | 8 | Data lines as driven by the host |
| bus_dout | output | 8 | Data lines as driven by the bridge |
| bus_oe | output | 1 | Output enable for `bus_dout` (tri-state control) |
| core_req | output | 1 | One-cycle request to the core |
| core_sel | output | 1 | Request target: 0 instruction, 1 data |
| core_wr | output | 1 | Request direction: 1 write, 0 read |
| core_wdata | output | 8 | Assembled write byte |
| core_ack | input | 1 | Core acknowledge |
| core_rdata | input | 8 | Data byte returned with `core_ack` |
| core_busy | input | 1 | Core busy flag |
| core_ac | input | 7 | Core address counter |

## Verification
The bench switches the bus width both ways and checks that the bridge follows each switch. A bridge that ignored the width command would request after every nibble or merge unrelated bytes. The bench drives garbage on the lower lines during nibble writes, so a bridge that used those lines would corrupt the assembled byte. It also abandons a nibble pair midway and then starts a status read: without the phase reset that read would return the low nibble first and a spurious request would appear. Prefetch ordering is checked by loading different `core_rdata` values before successive reads, which exposes any off-by-one between a read and the byte it returns.

// File: rtl/mpu_bus_bridge.sv
module mpu_bus_bridge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_e,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  output logic       core_req,
  output logic       core_sel,
  output logic       core_wr,
  output logic [7:0] core_wdata,
  input  logic       core_ack,
  input  logic [7:0] core_rdata,
  input  logic       core_busy,
  input  logic [6:0] core_ac
);

  logic [1:0] e_sy, rs_sy, rw_sy;
  logic [7:0] din_m, din_s;
  logic       e_d;
  logic       mode8, phase, last_rs, last_rw, rd_pend;
  logic [3:0] hi_nib;
  logic [7:0] hold, rd_buf, dout_q;
  logic       oe_q;

  wire e_s    = e_sy[1];
  wire rs_s   = rs_sy[1];
  wire rw_s   = rw_sy[1];
  wire e_rise = e_s & ~e_d;
  wire e_fall = ~e_s & e_d;

  wire       same_kind = (rs_s == last_rs) && (rw_s == last_rw);
  wire       eff_lo    = ~mode8 & phase & same_kind;
  wire [7:0] src       = rs_s ? rd_buf : {core_busy, core_ac};
  wire       done_byte = e_fall & (mode8 | eff_lo);
  wire [7:0] byte_val  = mode8 ? din_s : {hi_nib, din_s[7:4]};
  wire       is_status = ~rs_s & rw_s;
  wire       is_fnset  = ~rs_s & ~rw_s & (byte_val[7:5] == 3'b001);

  assign bus_dout = dout_q;
  assign bus_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_sy  <= '0;
      rs_sy <= '0;
      rw_sy <= '0;
      din_m <= '0;
      din_s <= '0;
      e_d   <= 1'b0;
    end else begin
      e_sy  <= {e_sy[0], bus_e};
      rs_sy <= {rs_sy[0], bus_rs};
      rw_sy <= {rw_sy[0], bus_rw};
      din_m <= bus_din;
      din_s <= din_m;
      e_d   <= e_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
      hold   <= '0;
    end else if (e_rise && rw_s) begin
      oe_q <= 1'b1;
      if (!eff_lo) hold <= src;
      if (mode8)       dout_q <= src;
      else if (eff_lo) dout_q <= {hold[3:0], 4'h0};
      else             dout_q <= {src[7:4], 4'h0};
    end else if (e_fall) begin
      oe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode8   <= 1'b1;
      phase   <= 1'b0;
      hi_nib  <= '0;
      last_rs <= 1'b0;
      last_rw <= 1'b0;
    end else if (e_fall) begin
      last_rs <= rs_s;
      last_rw <= rw_s;
      if (!mode8) begin
        phase <= ~eff_lo;
        if (!eff_lo) hi_nib <= din_s[7:4];
      end
      if (done_byte && is_fnset) begin
        mode8 <= byte_val[4];
        phase <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_req   <= 1'b0;
      core_sel   <= 1'b0;
      core_wr    <= 1'b0;
      core_wdata <= '0;
    end else begin
      core_req <= done_byte & ~is_status;
      if (done_byte) begin
        core_sel   <= rs_s;
        core_wr    <= ~rw_s;
        core_wdata <= byte_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_buf  <= '0;
    end else if (core_ack && rd_pend) begin
      rd_pend <= 1'b0;
      rd_buf  <= core_rdata;
    end else if (done_byte && rs_s && rw_s) begin
      rd_pend <= 1'b1;
    end
  end

  a_r2_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |=> !core_req);

  a_r4_no_status_request: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_wr) |-> core_sel);

  a_r5_oe_only_with_e: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> $past(e_s));

  a_r5_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(rw_s));

  a_r6_width_from_fnset: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode8) |-> $past(e_fall && !rs_s && !rw_s));

endmodule

// File: tb/mpu_bus_bridge_tb.sv
module mpu_bus_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       core_req, core_sel, core_wr;
  logic [7:0] core_wdata;
  logic       core_ack = 1'b0;
  logic [7:0] core_rdata = '0;
  logic       core_busy = 1'b0;
  logic [6:0] core_ac = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [9:0] expq[$];

  always #2 clk = ~clk;

  mpu_bus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .core_req(core_req), .core_sel(core_sel), .core_wr(core_wr),
    .core_wdata(core_wdata), .core_ack(core_ack), .core_rdata(core_rdata),
    .core_busy(core_busy), .core_ac(core_ac)
  );

  always @(posedge clk) core_ack <= core_req;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: every request is compared with the next expected item.
  always @(negedge clk) begin
    if (rst_n && core_req) begin
      logic [9:0] e;
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected request actual %b%b%h expected none",
                 core_sel, core_wr, core_wdata);
      end else begin
        e = expq.pop_front();
        if (core_sel !== e[9] || core_wr !== e[8] || (e[8] && core_wdata !== e[7:0])) begin
          errors++;
          $display("FAIL R2/R3/R7/R9 request actual %b%b%h expected %b%b%h",
                   core_sel, core_wr, core_wdata, e[9], e[8], e[7:0]);
        end
      end
    end
  end

  task automatic cycle(input logic rs, input logic rw, input logic [7:0] d,
                       output logic [7:0] rdat, output logic oe_hi);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_din = d;
    repeat (3) @(negedge clk);
    bus_e = 1'b1;
    repeat (6) @(negedge clk);
    rdat = bus_dout; oe_hi = bus_oe;
    bus_e = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 oe low after E", {7'b0, bus_oe}, 8'h00);
  endtask

  task automatic wr8(input logic rs, input logic [7:0] d);
    logic [7:0] r; logic o;
    expq.push_back({rs, 1'b1, d});
    cycle(rs, 1'b0, d, r, o);
    chk(rs ? "R3 oe during write" : "R2 oe during write", {7'b0, o}, 8'h00);
  endtask

  task automatic wr4(input logic rs, input logic [7:0] d, input logic [3:0] junk);
    logic [7:0] r; logic o;
    cycle(rs, 1'b0, {d[7:4], junk}, r, o);
    expq.push_back({rs, 1'b1, d});
    cycle(rs, 1'b0, {d[3:0], ~junk}, r, o);
    chk("R7 oe during nibble write", {7'b0, o}, 8'h00);
  endtask

  task automatic rd(input logic rs, input logic last, input logic [7:0] exp, input string req);
    logic [7:0] r; logic o;
    if (rs && last) expq.push_back({1'b1, 1'b0, 8'h00});
    cycle(rs, 1'b1, 8'h00, r, o);
    chk("R5 oe during read", {7'b0, o}, 8'h01);
    chk(req, r, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 oe at reset", {7'b0, bus_oe}, 8'h00);
    chk("R1 req at reset", {7'b0, core_req}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    wr8(1'b0, 8'h0C);
    wr8(1'b1, 8'h41);
    core_busy = 1'b1; core_ac = 7'h35;
    rd(1'b0, 1'b1, 8'hB5, "R4 status 8-bit");
    core_busy = 1'b0; core_ac = 7'h02;
    rd(1'b0, 1'b1, 8'h02, "R4 status not busy");

    core_rdata = 8'h5A;
    rd(1'b1, 1'b1, 8'h00, "R1 R9 first read gives reset buffer");
    core_rdata = 8'h9C;
    rd(1'b1, 1'b1, 8'h5A, "R9 prefetched byte");

    wr8(1'b0, 8'h20);
    wr4(1'b0, 8'h28, 4'hF);
    wr4(1'b1, 8'hC3, 4'h5);
    core_ac = 7'h5A;
    rd(1'b0, 1'b0, 8'h50, "R8 status high nibble");
    rd(1'b0, 1'b1, 8'hA0, "R8 status low nibble AC3..AC0");
    core_rdata = 8'h3E;
    rd(1'b1, 1'b0, 8'h90, "R8 R9 data high nibble");
    rd(1'b1, 1'b1, 8'hC0, "R8 R9 data low nibble");

    begin
      logic [7:0] r; logic o;
      cycle(1'b1, 1'b0, 8'h4F, r, o);
    end
    core_busy = 1'b1; core_ac = 7'h47;
    rd(1'b0, 1'b0, 8'hC0, "R10 status after aborted pair");
    rd(1'b0, 1'b1, 8'h70, "R10 status second nibble");
    core_busy = 1'b0;
    wr4(1'b0, 8'h0F, 4'hA);

    wr4(1'b0, 8'h30, 4'h0);
    wr8(1'b1, 8'hE7);
    core_rdata = 8'h11;
    rd(1'b1, 1'b1, 8'h3E, "R6 R9 8-bit read after width switch");

    repeat (10) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2/R3 missing requests actual %0d expected 0", expq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule